// File: doc/BRIEF.md
# External Sync Lock for Scan Counters

This block keeps a pair of internal scan counters, one for the dot position within a line and one for the line, locked to sync pulses that arrive from an external video source. The horizontal sync input is registered on the dot clock. A falling edge on it restarts the dot counter at the sync-start position, which is count zero. The same edge produces a one-cycle pulse that realigns any divided clock derived from the dot clock. When no edge arrives, the dot counter runs freely over a programmable line length.

The vertical sync input may carry a plain vertical pulse or a full composite sync. It is tested at points spaced one horizontal-sync width apart. Only a run of consecutive low samples counts as a vertical event, so the short equalizing and serration pulses of composite sync are rejected. A qualified event does not touch the line counter at once. It is held until the next line start, where the line counter restarts at zero. In interlaced mode the block also records where in the line the event was qualified, and reports odd or even field from that position.

Top module: `scan_sync_lock`

## Requirements
- R1: When `hs_in` is sampled high on one clock edge and low on the next, `h_cnt` reads 0 after the following edge, two edges after `hs_in` was first seen low, and then counts up by one per clock. Holding `hs_in` low causes no further restart.
- R2: `phase_rst` is high for exactly one cycle, the cycle in which `h_cnt` first reads 0 after an `hs_in` falling edge. It stays low when the counter wraps internally.
- R3: Without `hs_in` edges, `h_cnt` counts 0 to `cfg_line_len`-1 and then returns to 0. If `h_cnt` is at or beyond `cfg_line_len`-1, for example after the length was shortened, the next value is 0.
- R4: Every line start increments `v_cnt` by one. A line start is the clock edge where `h_cnt` becomes 0, whether from an internal wrap or from an `hs_in` edge.
- R5: `vs_in` passes through one register and is then sampled at `h_cnt` = W-1, 2W-1, and so on, counted from each line start, where W is `cfg_hs_width` and 0 behaves as 1. No sample is taken in a line-start cycle. Three consecutive low samples qualify a vertical event. Any high sample clears the run.
- R6: A qualified event leaves `v_cnt` unchanged until the next line start. At that line start `v_cnt` becomes 0 instead of incrementing.
- R7: After an event, and after reset, a new event cannot qualify until at least one high sample of `vs_in` has been taken. A `vs_in` held low across many lines gives one restart.
- R8: With `cfg_interlace` = 1, `field_odd` becomes 1 if `h_cnt` at the qualifying sample was below `cfg_line_len`/2 (rounded down), and 0 otherwise. It changes at the line start that applies the event and holds its value between events.
- R9: With `cfg_interlace` = 0, `field_odd` reads 0.
- R10: Synchronous reset sets `h_cnt`, `v_cnt`, `field_odd` and `phase_rst` to 0. The external sync inputs are treated as high at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_in | input | 1 | External horizontal sync, active low |
| vs_in | input | 1 | External vertical or composite sync, active low |
| cfg_line_len | input | H_W | Dots per line |
| cfg_hs_width | input | SW_W | Horizontal sync width in dots, which is also the vertical sample spacing |
| cfg_interlace | input | 1 | 1 selects interlaced field detection |
| h_cnt | output | H_W | Dot position within the line, 0 at sync start |
| v_cnt | output | V_W | Line count since the last vertical restart |
| field_odd | output | 1 | 1 for odd field, 0 for even field |
| phase_rst | output | 1 | One-cycle pulse that realigns the divided clock |

## Verification
Errors in the dot counter or the edge detector appear on `h_cnt` and `phase_rst` within two clocks of an `hs_in` edge. A mistake in the sample spacing, the low-run count or the re-arm rule cannot be seen in the cycle where it happens. It shows at the next line start, where `v_cnt` either restarts or increments, so it is visible no more than one line later. A field decision taken on the wrong side of mid-line shows on `field_odd` at that same line start. For this reason the checks are placed at the last dot of each line and at the first dot of the next.

// File: rtl/sync_lock_pkg.sv
package sync_lock_pkg;

    // widest position handled by the half-line comparison
    localparam int MAX_POS_W = 16;

    // vertical qualifier: waiting for a high sample, counting lows, event held for line start
    typedef enum logic [1:0] {
        QS_SPENT = 2'd0,
        QS_ARMED = 2'd1,
        QS_PEND  = 2'd2
    } qual_state_e;

    // registered view of the external sync pins
    typedef struct packed {
        logic hs_fall;
        logic vs_low;
    } sync_smp_t;

    // qualified vertical event handed to the line counter
    typedef struct packed {
        logic pend;
        logic odd;
    } vevent_t;

    function automatic logic in_first_half(input logic [MAX_POS_W-1:0] pos,
                                           input logic [MAX_POS_W-1:0] total);
        return pos < (total >> 1);
    endfunction

endpackage

// File: rtl/sync_input_smp.sv
module sync_input_smp
    import sync_lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hs_in,
    input  logic      vs_in,
    output sync_smp_t smp
);
    logic hs_q;
    logic hs_qq;
    logic vs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q  <= 1'b1;
            hs_qq <= 1'b1;
            vs_q  <= 1'b1;
        end else begin
            hs_q  <= hs_in;
            hs_qq <= hs_q;
            vs_q  <= vs_in;
        end
    end

    always_comb begin
        smp.hs_fall = hs_qq & ~hs_q;
        smp.vs_low  = ~vs_q;
    end
endmodule

// File: rtl/sync_hcount.sv
module sync_hcount #(
    parameter int H_W = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hs_fall,
    input  logic [H_W-1:0] line_len,
    output logic [H_W-1:0] h_cnt,
    output logic           line_start,
    output logic           phase_rst
);
    localparam logic [H_W-1:0] H_ONE = {{(H_W-1){1'b0}}, 1'b1};

    logic wrap;

    assign wrap       = (h_cnt >= (line_len - H_ONE));
    assign line_start = hs_fall | wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt     <= '0;
            phase_rst <= 1'b0;
        end else begin
            phase_rst <= hs_fall;
            h_cnt     <= line_start ? '0 : h_cnt + H_ONE;
        end
    end

    // R1
    hs_fall_zero_chk: assert property (@(posedge clk) disable iff (rst)
        hs_fall |=> (h_cnt == '0));

    // R2
    phase_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        phase_rst |-> (h_cnt == '0));
endmodule

// File: rtl/sync_vqual.sv
module sync_vqual
    import sync_lock_pkg::*;
#(
    parameter int H_W     = 12,
    parameter int SW_W    = 8,
    parameter int LOW_RUN = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            vs_low,
    input  logic            line_start,
    input  logic [H_W-1:0]  h_cnt,
    input  logic [H_W-1:0]  line_len,
    input  logic [SW_W-1:0] hs_width,
    output vevent_t         ev
);
    localparam int RUN_W = (LOW_RUN > 1) ? $clog2(LOW_RUN) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOW_RUN - 1);
    localparam logic [RUN_W-1:0] RUN_ONE  = {{(RUN_W-1){1'b0}}, 1'b1};
    localparam logic [SW_W-1:0]  S_ONE    = {{(SW_W-1){1'b0}}, 1'b1};

    logic [SW_W-1:0]  samp_cnt;
    logic [SW_W-1:0]  width_eff;
    logic             tick;
    qual_state_e      state;
    logic [RUN_W-1:0] run;
    logic             odd_q;

    assign width_eff = (hs_width == '0) ? S_ONE : hs_width;
    assign tick      = (samp_cnt >= (width_eff - S_ONE)) && !line_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_cnt <= '0;
            state    <= QS_SPENT;
            run      <= '0;
            odd_q    <= 1'b0;
        end else begin
            if (line_start || tick) samp_cnt <= '0;
            else                    samp_cnt <= samp_cnt + S_ONE;

            unique case (state)
                QS_SPENT: begin
                    if (tick && !vs_low) begin
                        state <= QS_ARMED;
                        run   <= '0;
                    end
                end
                QS_ARMED: begin
                    if (tick) begin
                        if (!vs_low) begin
                            run <= '0;
                        end else if (run == RUN_LAST) begin
                            state <= QS_PEND;
                            run   <= '0;
                            odd_q <= in_first_half(MAX_POS_W'(h_cnt), MAX_POS_W'(line_len));
                        end else begin
                            run <= run + RUN_ONE;
                        end
                    end
                end
                QS_PEND: begin
                    if (line_start) state <= QS_SPENT;
                end
                default: state <= QS_SPENT;
            endcase
        end
    end

    always_comb begin
        ev.pend = (state == QS_PEND);
        ev.odd  = odd_q;
    end

    // R5
    qual_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state == QS_PEND) |-> ($past(vs_low) && $past(tick)));

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == QS_PEND) && !line_start) |=> (state == QS_PEND));

    // R7
    no_arm_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == QS_SPENT) && vs_low) |=> (state == QS_SPENT));
endmodule

// File: rtl/sync_vcount.sv
module sync_vcount #(
    parameter int V_W = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           line_start,
    input  logic           pend,
    input  logic           odd,
    input  logic           interlace,
    output logic [V_W-1:0] v_cnt,
    output logic           field_odd
);
    localparam logic [V_W-1:0] V_ONE = {{(V_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            v_cnt     <= '0;
            field_odd <= 1'b0;
        end else begin
            if (line_start) v_cnt <= pend ? '0 : v_cnt + V_ONE;
            if (!interlace)              field_odd <= 1'b0;
            else if (line_start && pend) field_odd <= odd;
        end
    end

    // R4
    v_line_only_chk: assert property (@(posedge clk) disable iff (rst)
        !line_start |=> $stable(v_cnt));

    // R6
    v_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (line_start && pend) |=> (v_cnt == '0));

    // R9
    prog_field_chk: assert property (@(posedge clk) disable iff (rst)
        !interlace |=> !field_odd);
endmodule

// File: rtl/scan_sync_lock.sv
module scan_sync_lock
    import sync_lock_pkg::*;
#(
    parameter int H_W     = 12,
    parameter int V_W     = 11,
    parameter int SW_W    = 8,
    parameter int LOW_RUN = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hs_in,
    input  logic            vs_in,
    input  logic [H_W-1:0]  cfg_line_len,
    input  logic [SW_W-1:0] cfg_hs_width,
    input  logic            cfg_interlace,
    output logic [H_W-1:0]  h_cnt,
    output logic [V_W-1:0]  v_cnt,
    output logic            field_odd,
    output logic            phase_rst
);
    sync_smp_t smp;
    vevent_t   ev;
    logic      line_start;

    sync_input_smp u_smp (
        .clk   (clk),
        .rst   (rst),
        .hs_in (hs_in),
        .vs_in (vs_in),
        .smp   (smp)
    );

    sync_hcount #(.H_W(H_W)) u_h (
        .clk        (clk),
        .rst        (rst),
        .hs_fall    (smp.hs_fall),
        .line_len   (cfg_line_len),
        .h_cnt      (h_cnt),
        .line_start (line_start),
        .phase_rst  (phase_rst)
    );

    sync_vqual #(.H_W(H_W), .SW_W(SW_W), .LOW_RUN(LOW_RUN)) u_q (
        .clk        (clk),
        .rst        (rst),
        .vs_low     (smp.vs_low),
        .line_start (line_start),
        .h_cnt      (h_cnt),
        .line_len   (cfg_line_len),
        .hs_width   (cfg_hs_width),
        .ev         (ev)
    );

    sync_vcount #(.V_W(V_W)) u_v (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .pend       (ev.pend),
        .odd        (ev.odd),
        .interlace  (cfg_interlace),
        .v_cnt      (v_cnt),
        .field_odd  (field_odd)
    );
endmodule

// File: tb/scan_sync_lock_test.sv
module scan_sync_lock_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs_in = 1'b1;
    logic        vs_in = 1'b1;
    logic [11:0] cfg_line_len = 12'd40;
    logic [7:0]  cfg_hs_width = 8'd4;
    logic        cfg_interlace = 1'b0;
    logic [11:0] h_cnt;
    logic [10:0] v_cnt;
    logic        field_odd;
    logic        phase_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    scan_sync_lock uut (
        .clk           (clk),
        .rst           (rst),
        .hs_in         (hs_in),
        .vs_in         (vs_in),
        .cfg_line_len  (cfg_line_len),
        .cfg_hs_width  (cfg_hs_width),
        .cfg_interlace (cfg_interlace),
        .h_cnt         (h_cnt),
        .v_cnt         (v_cnt),
        .field_odd     (field_odd),
        .phase_rst     (phase_rst)
    );

    always #2 clk = ~clk;

    // columns: interlace, low start dot, low length, restart expected, field (2 = unchanged)
    localparam int NVEC = 7;
    localparam int VEC [0:NVEC-1][0:4] = '{
        '{1, 10, 20, 1, 1},
        '{0, 10, 20, 1, 0},
        '{1, 26, 12, 1, 0},
        '{1, 10,  8, 0, 2},
        '{1,  8, 12, 1, 1},
        '{1, 14,  8, 0, 2},
        '{1, 14,  9, 1, 0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_h(input int target);
        int guard = 0;
        while (int'(h_cnt) != target && guard < 500) begin
            step();
            guard++;
        end
        if (guard >= 500) check("R3 dot position reached", 0, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int pv;
        int pf;
        int ef;
        step(3);
        // R10 reset state
        check("R10 h_cnt", int'(h_cnt), 0);
        check("R10 v_cnt", int'(v_cnt), 0);
        check("R10 field_odd", int'(field_odd), 0);
        check("R10 phase_rst", int'(phase_rst), 0);
        rst = 1'b0;
        step();
        check("R3 first count", int'(h_cnt), 1);

        // R3 R4 internal wrap, R2 no pulse on wrap
        wait_h(39);
        check("R4 v before wrap", int'(v_cnt), 0);
        step();
        check("R3 wrap to 0", int'(h_cnt), 0);
        check("R4 v after wrap", int'(v_cnt), 1);
        check("R2 no pulse on wrap", int'(phase_rst), 0);

        // R1 R2 external horizontal lock
        wait_h(17);
        hs_in = 1'b0;
        step();
        check("R1 no restart yet", int'(h_cnt), 18);
        step();
        check("R1 restart at sync start", int'(h_cnt), 0);
        check("R2 phase pulse", int'(phase_rst), 1);
        check("R4 v on hs edge", int'(v_cnt), 2);
        step();
        check("R2 pulse one cycle", int'(phase_rst), 0);
        check("R1 count resumes", int'(h_cnt), 1);
        step(10);
        check("R1 held low no restart", int'(h_cnt), 11);
        hs_in = 1'b1;
        wait_h(0);

        // R5 R6 R8 R9 vector table
        for (int i = 0; i < NVEC; i++) begin
            cfg_interlace = VEC[i][0][0];
            wait_h(VEC[i][1]);
            pv = int'(v_cnt);
            pf = int'(field_odd);
            vs_in = 1'b0;
            step(VEC[i][2]);
            vs_in = 1'b1;
            wait_h(39);
            check("R6 v held until line start", int'(v_cnt), pv);
            step();
            check("R4 line start", int'(h_cnt), 0);
            check(VEC[i][3] != 0 ? "R6 v restart" : "R5 short run ignored",
                  int'(v_cnt), VEC[i][3] != 0 ? 0 : pv + 1);
            ef = (VEC[i][4] == 2) ? pf : VEC[i][4];
            check(VEC[i][0] != 0 ? "R8 field" : "R9 progressive field", int'(field_odd), ef);
        end

        // R7 held low across lines restarts once
        cfg_interlace = 1'b1;
        wait_h(10);
        vs_in = 1'b0;
        step();
        wait_h(0);
        check("R6 restart on long low", int'(v_cnt), 0);
        check("R8 odd on early event", int'(field_odd), 1);
        step();
        wait_h(0);
        check("R7 no second restart", int'(v_cnt), 1);
        step();
        wait_h(0);
        check("R7 still no restart", int'(v_cnt), 2);
        vs_in = 1'b1;
        wait_h(20);
        vs_in = 1'b0;
        step();
        wait_h(0);
        check("R7 re-armed after high", int'(v_cnt), 0);
        check("R8 even on late event", int'(field_odd), 0);
        vs_in = 1'b1;

        // R10 R7 reset with sync low needs high sample first
        vs_in = 1'b0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step();
        wait_h(0);
        check("R7 no event after reset while low", int'(v_cnt), 1);
        step();
        wait_h(0);
        check("R7 still counting after reset", int'(v_cnt), 2);
        vs_in = 1'b1;
        step();
        wait_h(0);

        // R5 wider sample spacing: W=8 gives samples at 7,15,23,31
        cfg_hs_width = 8'd8;
        wait_h(8);
        pv = int'(v_cnt);
        vs_in = 1'b0;
        step(20);
        vs_in = 1'b1;
        wait_h(39);
        step();
        check("R5 two wide samples ignored", int'(v_cnt), pv + 1);
        wait_h(4);
        vs_in = 1'b0;
        step(30);
        vs_in = 1'b1;
        wait_h(39);
        step();
        check("R5 three wide samples restart", int'(v_cnt), 0);
        check("R8 even at dot 23", int'(field_odd), 0);

        // R3 shortened line
        wait_h(30);
        pv = int'(v_cnt);
        cfg_line_len = 12'd24;
        step();
        check("R3 beyond new length wraps", int'(h_cnt), 0);
        check("R4 v on forced wrap", int'(v_cnt), pv + 1);
        wait_h(23);
        step();
        check("R3 wrap at new length", int'(h_cnt), 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule